// File: doc/BRIEF.md
# System Control Register Bank

A 32-bit register slave occupying a 4 KB window (word addressed) that gathers board-level control and status into one place. It stores a user LED register, a general-purpose control word, and an optional debug control word. It returns the level of external push-button and switch inputs, and keeps two wall-clock tick counters running at 1 Hz and 100 Hz. The tick rates come from dividing the bus clock, whose frequency is a parameter.

A separate prescaled event-counter block lives outside this bank. Its three words (event count, reload value, live prescale count) are decoded here and passed through on a small strobe-and-select port. The bus is a single-cycle read/write port. Each access presents a strobe, a word address and write data. Read data and an error flag for unmapped accesses appear one cycle after the strobe.

Top module: `sysctl_regbank`

## Requirements
- R1: Word addresses (byte offset / 4) decode as follows: LED 0, debug control 1, buttons 2, 1 Hz counter 4, 100 Hz counter 5, external event count 6, external reload 7, external prescale count 8, switches 10, general control 19. A mapped access leaves `rsp_err` low.
- R2: A write to the LED word stores only the low NUM_LEDS bits (default 2). `led_o` carries them active high from the edge of the write. A read returns them zero-extended. `led_o` changes only on an LED write.
- R3: With NUM_LEDS = 0 the LED word stays mapped, but writes are ignored and reads return 0.
- R4: The debug word (word 1) exists only when HAS_DBG = 1 and the switch word (word 10) only when HAS_SW = 1. When disabled, each behaves exactly as an unmapped address.
- R5: A read of an unmapped word returns 0 and a write to one changes nothing. Either access raises `rsp_err` for exactly the one cycle after the strobe.
- R6: The general control word and the debug word hold and return whatever was last written.
- R7: Reads of the button word and the switch word return `btn_i` and `sw_i` zero-extended to 32 bits.
- R8: Each tick counter increments by one every CLK_HZ (1 Hz) or CLK_HZ/100 (100 Hz) bus cycles, and by at most one per cycle.
- R9: Writing a tick counter loads the written value and restarts its phase. A read n cycles after the write edge returns value + floor((n-1)/period).
- R10: Reset clears the LED, general control and debug words, both tick counters and their phases.
- R11: Accesses to words 6, 7 and 8 drive `ext_rd_o`/`ext_wr_o` in the same cycle as the strobe, with `ext_sel_o` = 0, 1, 2 respectively. `ext_wdata_o` carries the write data, and a read returns `ext_rdata_i`.
- R12: `rsp_rdata` is registered and holds the selected word in the cycle after a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after `req_rd` |
| rsp_err | output | 1 | Unmapped-access pulse, one cycle after the strobe |
| led_o | output | max(NUM_LEDS,1) | Active-high LED drive |
| btn_i | input | BTN_W | Push-button levels |
| sw_i | input | SW_W | Switch levels |
| ext_rd_o | output | 1 | Read strobe to the external counter block |
| ext_wr_o | output | 1 | Write strobe to the external counter block |
| ext_sel_o | output | 2 | External word select: 0 event, 1 reload, 2 prescale |
| ext_wdata_o | output | 32 | Write data to the external block |
| ext_rdata_i | input | 32 | Read data from the external block, same cycle |

## Verification
Read data and the error pulse belong to the rising edge that samples the strobe. The monitor compares them at the falling edge that follows, so the queue is popped exactly one cycle after each access. LED levels, stored words and external strobes are checked at the falling edge after the write edge, where the registered value has already settled. Tick-counter expectations come from the bench's own edge count. It records the edge of the load and the edge of the read, and applies value + floor((n-1)/period). Two reads placed either side of a period boundary confirm the increment lands on the expected cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_LED,
      SEL_DBG,
      SEL_BTN,
      SEL_T1,
      SEL_T100,
      SEL_EVT,
      SEL_RLD,
      SEL_PSC,
      SEL_SW,
      SEL_CTL
   } sel_e;

   // word addresses; neighbouring software depends on these positions
   localparam int W_LED  = 0;
   localparam int W_DBG  = 1;
   localparam int W_BTN  = 2;
   localparam int W_T1   = 4;
   localparam int W_T100 = 5;
   localparam int W_EVT  = 6;
   localparam int W_RLD  = 7;
   localparam int W_PSC  = 8;
   localparam int W_SW   = 10;
   localparam int W_CTL  = 19;

   localparam int DATA_W = 32;

   function automatic logic is_ext(sel_e s);
      return (s == SEL_EVT) || (s == SEL_RLD) || (s == SEL_PSC);
   endfunction

   function automatic logic [1:0] ext_index(sel_e s);
      case (s)
         SEL_RLD: return 2'd1;
         SEL_PSC: return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter bit HAS_DBG = 1'b0,
   parameter bit HAS_SW  = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_e              sel
);

   always_comb begin
      sel = SEL_NONE;
      case (addr)
         ADDR_W'(W_LED):  sel = SEL_LED;
         ADDR_W'(W_DBG):  sel = HAS_DBG ? SEL_DBG : SEL_NONE;
         ADDR_W'(W_BTN):  sel = SEL_BTN;
         ADDR_W'(W_T1):   sel = SEL_T1;
         ADDR_W'(W_T100): sel = SEL_T100;
         ADDR_W'(W_EVT):  sel = SEL_EVT;
         ADDR_W'(W_RLD):  sel = SEL_RLD;
         ADDR_W'(W_PSC):  sel = SEL_PSC;
         ADDR_W'(W_SW):   sel = HAS_SW ? SEL_SW : SEL_NONE;
         ADDR_W'(W_CTL):  sel = SEL_CTL;
         default:         sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/sysctl_tick_ctr.sv
module sysctl_tick_ctr #(
   parameter int DIV   = 100,
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count
);

   localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

   logic [PH_W-1:0]  ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;

   assign wrap  = (ph_q == PH_LAST);
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         ph_q  <= '0;
         cnt_q <= load_val;
      end else if (wrap) begin
         ph_q  <= '0;
         cnt_q <= cnt_q + 1'b1;
      end else begin
         ph_q  <= ph_q + 1'b1;
      end
   end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
   import sysctl_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int ADDR_W   = 10,
   parameter int NUM_LEDS = 2,
   parameter int BTN_W    = 4,
   parameter int SW_W     = 8,
   parameter bit HAS_DBG  = 1'b0,
   parameter bit HAS_SW   = 1'b0,
   localparam int LED_W   = (NUM_LEDS > 0) ? NUM_LEDS : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_rd,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       rsp_rdata,
   output logic              rsp_err,
   output logic [LED_W-1:0]  led_o,
   input  logic [BTN_W-1:0]  btn_i,
   input  logic [SW_W-1:0]   sw_i,
   output logic              ext_rd_o,
   output logic              ext_wr_o,
   output logic [1:0]        ext_sel_o,
   output logic [31:0]       ext_wdata_o,
   input  logic [31:0]       ext_rdata_i
);

   localparam int DIV_SLOW = CLK_HZ;
   localparam int DIV_FAST = CLK_HZ / 100;

   initial begin
      assert (CLK_HZ >= 200 && (CLK_HZ % 100) == 0)
         else $error("CLK_HZ must be a multiple of 100 of at least 200");
      assert (NUM_LEDS >= 0 && NUM_LEDS <= DATA_W)
         else $error("NUM_LEDS out of range");
      assert (BTN_W >= 1 && BTN_W <= DATA_W) else $error("BTN_W out of range");
      assert (SW_W >= 1 && SW_W <= DATA_W) else $error("SW_W out of range");
      assert (ADDR_W >= 5) else $error("ADDR_W too small for the map");
   end

   sel_e sel;

   sysctl_decode #(
      .ADDR_W (ADDR_W),
      .HAS_DBG(HAS_DBG),
      .HAS_SW (HAS_SW)
   ) u_dec (
      .addr(req_addr),
      .sel (sel)
   );

   logic wr_hit_led, wr_hit_dbg, wr_hit_ctl;
   assign wr_hit_led = req_wr && (sel == SEL_LED);
   assign wr_hit_dbg = req_wr && (sel == SEL_DBG);
   assign wr_hit_ctl = req_wr && (sel == SEL_CTL);

   // ---------------- LED word ----------------
   logic [31:0] led_rd;
   generate
      if (NUM_LEDS > 0) begin : g_led
         logic [NUM_LEDS-1:0] led_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          led_q <= '0;
            else if (wr_hit_led) led_q <= req_wdata[NUM_LEDS-1:0];
         end
         assign led_o  = led_q;
         assign led_rd = 32'(led_q);
      end else begin : g_noled
         assign led_o  = '0;
         assign led_rd = '0;
      end
   endgenerate

   // ---------------- debug word ----------------
   logic [31:0] dbg_rd;
   generate
      if (HAS_DBG) begin : g_dbg
         logic [31:0] dbg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          dbg_q <= '0;
            else if (wr_hit_dbg) dbg_q <= req_wdata;
         end
         assign dbg_rd = dbg_q;
      end else begin : g_nodbg
         logic unused_dbg;
         assign unused_dbg = wr_hit_dbg;
         assign dbg_rd     = '0;
      end
   endgenerate

   // ---------------- switch word ----------------
   logic [31:0] sw_rd;
   generate
      if (HAS_SW) begin : g_sw
         assign sw_rd = 32'(sw_i);
      end else begin : g_nosw
         logic unused_sw;
         assign unused_sw = ^sw_i;
         assign sw_rd     = '0;
      end
   endgenerate

   // ---------------- general control word ----------------
   logic [31:0] ctl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ctl_q <= '0;
      else if (wr_hit_ctl) ctl_q <= req_wdata;
   end

   // ---------------- tick counters ----------------
   logic [31:0] tb_cnt [2];
   generate
      for (genvar g = 0; g < 2; g++) begin : g_tick
         localparam int   DIV_G = (g == 0) ? DIV_SLOW : DIV_FAST;
         localparam sel_e SEL_G = (g == 0) ? SEL_T1 : SEL_T100;
         sysctl_tick_ctr #(
            .DIV  (DIV_G),
            .CNT_W(32)
         ) u_tick (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (req_wr && (sel == SEL_G)),
            .load_val(req_wdata),
            .count   (tb_cnt[g])
         );
      end
   endgenerate

   // ---------------- external counter pass-through ----------------
   assign ext_rd_o    = req_rd && is_ext(sel);
   assign ext_wr_o    = req_wr && is_ext(sel);
   assign ext_sel_o   = ext_index(sel);
   assign ext_wdata_o = req_wdata;

   // ---------------- read mux and response ----------------
   logic [31:0] rd_mux;
   always_comb begin
      case (sel)
         SEL_LED:  rd_mux = led_rd;
         SEL_DBG:  rd_mux = dbg_rd;
         SEL_BTN:  rd_mux = 32'(btn_i);
         SEL_T1:   rd_mux = tb_cnt[0];
         SEL_T100: rd_mux = tb_cnt[1];
         SEL_EVT,
         SEL_RLD,
         SEL_PSC:  rd_mux = ext_rdata_i;
         SEL_SW:   rd_mux = sw_rd;
         SEL_CTL:  rd_mux = ctl_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         if (req_rd) rsp_rdata <= rd_mux;
         rsp_err <= (req_rd || req_wr) && (sel == SEL_NONE);
      end
   end

endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
   parameter int ADDR_W = 10,
   parameter int LED_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_rd,
   input logic              req_wr,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_err,
   input logic [LED_W-1:0]  led_o,
   input logic              ext_rd_o,
   input logic              ext_wr_o,
   input logic [31:0]       fast_cnt
);

   AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(req_rd || req_wr)); // R5

   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_wr && req_addr == ADDR_W'(0)) |=> $stable(led_o)); // R2

   AST_EXT_RD_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rd_o |-> req_rd); // R11

   AST_EXT_WR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr_o |-> req_wr); // R11

   AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_wr && req_addr == ADDR_W'(5)) |=>
         (fast_cnt == $past(fast_cnt) || fast_cnt == $past(fast_cnt) + 32'd1)); // R8

endmodule

bind sysctl_regbank sysctl_regbank_chk #(
   .ADDR_W(ADDR_W),
   .LED_W (LED_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_rd  (req_rd),
   .req_wr  (req_wr),
   .req_addr(req_addr),
   .rsp_err (rsp_err),
   .led_o   (led_o),
   .ext_rd_o(ext_rd_o),
   .ext_wr_o(ext_wr_o),
   .fast_cnt(tb_cnt[1])
);

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;

   localparam int HZ   = 1000;
   localparam int FAST = HZ / 100;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        rd0, wr0, rd1, wr1;
   logic [9:0]  addr;
   logic [31:0] wdata;
   logic [3:0]  btn;
   logic [7:0]  sw;

   logic [31:0] rdata0, rdata1, ewd0, ewd1, erd0, erd1;
   logic        err0, err1, erdo0, ewro0, erdo1, ewro1;
   logic [1:0]  led0, esel0, esel1;
   logic [0:0]  led1;

   assign erd0 = 32'hE000_0000 | {30'd0, esel0};
   assign erd1 = 32'hE000_0000 | {30'd0, esel1};

   sysctl_regbank #(.CLK_HZ(HZ), .NUM_LEDS(2), .HAS_DBG(1'b1), .HAS_SW(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_rd(rd0), .req_wr(wr0), .req_addr(addr),
      .req_wdata(wdata), .rsp_rdata(rdata0), .rsp_err(err0), .led_o(led0),
      .btn_i(btn), .sw_i(sw), .ext_rd_o(erdo0), .ext_wr_o(ewro0),
      .ext_sel_o(esel0), .ext_wdata_o(ewd0), .ext_rdata_i(erd0));

   sysctl_regbank #(.CLK_HZ(HZ), .NUM_LEDS(0), .HAS_DBG(1'b0), .HAS_SW(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .req_rd(rd1), .req_wr(wr1), .req_addr(addr),
      .req_wdata(wdata), .rsp_rdata(rdata1), .rsp_err(err1), .led_o(led1),
      .btn_i(btn), .sw_i(sw), .ext_rd_o(erdo1), .ext_wr_o(ewro1),
      .ext_sel_o(esel1), .ext_wdata_o(ewd1), .ext_rdata_i(erd1));

   typedef struct {
      int          inst;
      bit          chk;
      logic [31:0] d;
      bit          e;
      string       tag;
   } item_t;

   item_t q[$];
   int    nchk = 0, nfail = 0, cyc = 0;
   bit    done = 0;

   logic        acc0_q = 0, acc1_q = 0;
   logic [1:0]  cap_sel;
   logic [31:0] cap_wd;
   int          cap_n = 0;

   always @(posedge clk) begin
      cyc    <= cyc + 1;
      acc0_q <= rd0 | wr0;
      acc1_q <= rd1 | wr1;
      if (ewro0) begin
         cap_sel <= esel0;
         cap_wd  <= ewd0;
         cap_n   <= cap_n + 1;
      end
   end

   // monitor: pops one expected item per access, one cycle after its strobe
   logic [31:0] got_d;
   logic        got_e;
   item_t       it;
   always @(negedge clk) begin
      if (acc0_q || acc1_q) begin
         nchk++;
         if (q.size() == 0) begin
            nfail++;
            $display("FAIL R12: response with no expected item (act=1 exp=0)");
         end else begin
            it    = q.pop_front();
            got_d = (it.inst == 0) ? rdata0 : rdata1;
            got_e = (it.inst == 0) ? err0 : err1;
            if ((it.chk && got_d !== it.d) || got_e !== it.e) begin
               nfail++;
               $display("FAIL %s: act data=%h err=%b exp data=%h err=%b",
                        it.tag, got_d, got_e, it.d, it.e);
            end
         end
      end
   end

   // driver: called at a falling edge, returns at the next falling edge
   task automatic acc(input int inst, input bit wr, input int waddr,
                      input logic [31:0] wd, input logic [31:0] exp_d,
                      input bit exp_e, input string tag);
      item_t x;
      addr  = waddr[9:0];
      wdata = wd;
      if (inst == 0) begin rd0 = !wr; wr0 = wr; end
      else           begin rd1 = !wr; wr1 = wr; end
      x.inst = inst; x.chk = !wr; x.d = exp_d; x.e = exp_e; x.tag = tag;
      q.push_back(x);
      @(negedge clk);
      rd0 = 0; wr0 = 0; rd1 = 0; wr1 = 0;
   endtask

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp_v);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp_v);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] tick_exp(logic [31:0] v, int wedge, int redge, int per);
      return v + 32'((redge - wedge - 1) / per);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int we, re, n0;
      rst_n = 0; rd0 = 0; wr0 = 0; rd1 = 0; wr1 = 0;
      addr = '0; wdata = '0; btn = '0; sw = '0;
      idle(3);
      rst_n = 1;

      // R10 reset state
      acc(0, 0, 4, 0, 32'd0, 0, "R10 slow counter after reset");
      acc(0, 0, 5, 0, 32'd0, 0, "R10 fast counter after reset");
      acc(0, 0, 0, 0, 32'd0, 0, "R10 LED after reset");
      acc(0, 0, 19, 0, 32'd0, 0, "R10 control after reset");
      acc(0, 0, 1, 0, 32'd0, 0, "R10 debug after reset");
      chk(led0 == 2'b00, "R10 led_o after reset", 32'(led0), 0);

      // R2 LED mask and drive
      acc(0, 1, 0, 32'hFFFF_FFFD, 0, 0, "R2 LED write");
      chk(led0 == 2'b01, "R2 led_o after write", 32'(led0), 1);
      acc(0, 0, 0, 0, 32'd1, 0, "R2 R1 LED read masked");
      acc(0, 1, 0, 32'h0000_0002, 0, 0, "R2 LED write 2");
      chk(led0 == 2'b10, "R2 led_o second pattern", 32'(led0), 2);

      // R3 no LEDs
      acc(1, 1, 0, 32'h3, 0, 0, "R3 LED write ignored");
      acc(1, 0, 0, 0, 32'd0, 0, "R3 LED reads zero");
      chk(led1 == 1'b0, "R3 led_o stays low", 32'(led1), 0);

      // R6 stored words, R12 one-cycle read latency via monitor
      acc(0, 1, 19, 32'hA5A5_1234, 0, 0, "R6 control write");
      acc(0, 0, 19, 0, 32'hA5A5_1234, 0, "R6 R12 control readback");
      acc(0, 1, 1, 32'h0BAD_F00D, 0, 0, "R6 debug write");
      acc(0, 0, 1, 0, 32'h0BAD_F00D, 0, "R6 R1 debug readback");

      // R7 inputs
      btn = 4'hA; sw = 8'h5A;
      acc(0, 0, 2, 0, 32'h0000_000A, 0, "R7 buttons");
      acc(0, 0, 10, 0, 32'h0000_005A, 0, "R7 switches");

      // R4 disabled optional words
      acc(1, 0, 1, 0, 32'd0, 1, "R4 debug absent read");
      acc(1, 0, 10, 0, 32'd0, 1, "R4 switch absent read");
      acc(1, 1, 1, 32'hFFFF_FFFF, 0, 1, "R4 debug absent write");

      // R5 unmapped
      acc(0, 0, 3, 0, 32'd0, 1, "R5 unmapped read");
      acc(0, 1, 12, 32'hFFFF_FFFF, 0, 1, "R5 unmapped write");
      idle(1);
      chk(err0 == 1'b0, "R5 error pulse one cycle", 32'(err0), 0);
      acc(0, 0, 19, 0, 32'hA5A5_1234, 0, "R5 control untouched");
      acc(0, 0, 0, 0, 32'd2, 0, "R5 LED untouched");

      // R11 external pass-through
      acc(0, 0, 6, 0, 32'hE000_0000, 0, "R11 event word");
      acc(0, 0, 7, 0, 32'hE000_0001, 0, "R11 reload word");
      acc(0, 0, 8, 0, 32'hE000_0002, 0, "R11 prescale word");
      n0 = cap_n;
      acc(0, 1, 8, 32'h0000_1234, 0, 0, "R11 prescale write");
      chk(cap_n == n0 + 1 && cap_sel == 2'd2 && cap_wd == 32'h1234,
          "R11 write strobe", cap_wd, 32'h1234);

      // R8 R9 fast counter with phase restart at a period boundary
      we = cyc + 1;
      acc(0, 1, 5, 32'd100, 0, 0, "R9 fast load");
      idle(FAST - 1);
      re = cyc + 1;
      acc(0, 0, 5, 0, tick_exp(100, we, re, FAST), 0, "R9 fast before boundary");
      re = cyc + 1;
      acc(0, 0, 5, 0, tick_exp(100, we, re, FAST), 0, "R8 fast at boundary");
      we = cyc + 1;
      acc(0, 1, 5, 32'd50, 0, 0, "R9 fast reload");
      idle(23);
      re = cyc + 1;
      acc(0, 0, 5, 0, tick_exp(50, we, re, FAST), 0, "R8 fast after periods");

      // R8 R9 slow counter
      we = cyc + 1;
      acc(0, 1, 4, 32'd7, 0, 0, "R9 slow load");
      idle(HZ - 1);
      re = cyc + 1;
      acc(0, 0, 4, 0, tick_exp(7, we, re, HZ), 0, "R8 slow after one period");

      idle(2);
      chk(q.size() == 0, "R12 all responses seen", 32'(q.size()), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule